// File: doc/BRIEF.md
# Bidirectional Read-Modify-Write I/O Port

This block is an 8-bit general-purpose I/O port for a small processor core whose instruction cycle is split into four phases, Q1 through Q4, one clock each. Every pin has an output data latch and a direction bit. A pin set to output drives its latch value. A pin set to input is released, so an external pull or another device sets its level. Releasing a pin and driving only one level gives wired-OR or wired-AND sharing of a line.

The processor side issues one operation per instruction cycle and holds it for all four phases. The operations are a full-byte write, a full-byte read, a bit-set, a bit-clear and a direction write. Pin levels are sampled at the end of Q1 and every latch update commits at the end of Q4. Bit-set and bit-clear work on the sampled pin levels and not on the latch contents. Every pin's latch is rewritten, so an input-mode pin's latch picks up the level found on the pin. A read issued straight after a write can still see the old level if the board is slow to settle.

The pads are exposed as a drive value, a drive enable and a sensed level. The wired resolution of the net lives outside the block.

Top module: `gpio_rmw_port`

## Requirements
- R1: While reset is held and after its release, every direction bit is 1 (input). `pad_oe_o` is 8'h00 and `pad_o` is 8'h00.
- R2: An operation code of 1 (byte write) loads `wdata_i` into the data latches at the clock edge where `phase_i` is 3 (Q4). Each output-mode pin then drives its latch bit on `pad_o`.
- R3: An operation code of 5 (direction write) loads `wdata_i` into the direction bits at the Q4 edge. A 1 makes a pin an input, with `pad_oe_o` low and `pad_o` parked at 0. A 0 makes it an output, with `pad_oe_o` high.
- R4: Operation codes 2 (read), 3 (bit-set) and 4 (bit-clear) capture `pad_i` into `rdata_o` at the clock edge where `phase_i` is 0 (Q1). All bits are captured, whatever their direction. `rdata_o` holds its value at every other edge.
- R5: Operation code 3 writes the Q1 sample with bit `bit_i` forced to 1 into all data latches at the Q4 edge.
- R6: Operation code 4 writes the Q1 sample with bit `bit_i` forced to 0 into all data latches at the Q4 edge.
- R7: A bit-set or bit-clear replaces the latch of each input-mode pin with that pin's sampled level. A pin later switched to output drives that level, not the last byte written.
- R8: A read in the cycle right after a write returns the new level when the pin settles with no delay. It returns the previous level when the pin takes one phase or more to settle.
- R9: Operation code 0 (none) changes no latch, direction bit or `rdata_o`.
- R10: Latches and direction bits change only at edges where `phase_i` is 3 (Q4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| phase_i | input | 2 | Current phase: 0=Q1, 1=Q2, 2=Q3, 3=Q4 |
| op_i | input | 3 | Operation: 0 none, 1 write, 2 read, 3 bit-set, 4 bit-clear, 5 direction write |
| bit_i | input | 3 | Bit index for bit-set and bit-clear |
| wdata_i | input | 8 | Write data for byte and direction writes |
| rdata_o | output | 8 | Pin levels captured at the last sampling edge |
| pad_i | input | 8 | Sensed pin levels after board resolution |
| pad_o | output | 8 | Pad drive value, 0 for released pins |
| pad_oe_o | output | 8 | Pad drive enable, 1 for output-mode pins |

## Verification
The bench builds the port with its default width of 8 and a 2-stage reset synchronizer. At this size every one of the 256 direction patterns can be swept with a matching write and read, and every bit index can be tried for both bit-set and bit-clear against pins that are partly inputs and partly outputs. The bench resolves each pin from the drive enable and an external pull level. It feeds the result back through a delay line of 0 to 3 phases, which brings the stale-read case of a back-to-back write and read within reach.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_BSET  = 3'd3,
    OP_BCLR  = 3'd4,
    OP_DIRW  = 3'd5
  } op_e;

  function automatic logic op_samples(input op_e op);
    return (op == OP_READ) || (op == OP_BSET) || (op == OP_BCLR);
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      assign sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/gpio_sampler.sv
module gpio_sampler
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  op_e              op_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] smp_o
);

  logic             smp_en;
  logic [WIDTH-1:0] smp_d;
  logic [WIDTH-1:0] smp_q;

  assign smp_en = (phase_i == PH_Q1) && op_samples(op_i);

  always_comb begin
    smp_d = smp_q;
    if (smp_en) smp_d = pad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_d;
  end

  assign smp_o = smp_q;

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !((phase_i == PH_Q1) && op_samples(op_i)) |=> $stable(smp_o)); // R4

  AST_SAMPLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_i == PH_Q1) && (op_i == OP_READ)) |=> (smp_o == $past(pad_i))); // R4

  AST_IDLE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NONE) |=> $stable(smp_o)); // R9

endmodule

// File: rtl/gpio_latches.sv
module gpio_latches
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_i,
  input  op_e              op_i,
  input  logic [IDX_W-1:0] bit_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] smp_i,
  output logic [WIDTH-1:0] lat_o,
  output logic [WIDTH-1:0] dir_o
);

  logic             commit_en;
  logic [WIDTH-1:0] mask;
  logic [WIDTH-1:0] lat_d;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] dir_q;

  assign commit_en = (phase_i == PH_Q4);

  always_comb begin
    mask        = '0;
    mask[bit_i] = 1'b1;
  end

  // next-state: read-modify-write works on the Q1 pin sample
  always_comb begin
    lat_d = lat_q;
    dir_d = dir_q;
    unique case (op_i)
      OP_WRITE: lat_d = wdata_i;
      OP_BSET:  lat_d = smp_i | mask;
      OP_BCLR:  lat_d = smp_i & ~mask;
      OP_DIRW:  dir_d = wdata_i;
      default:  ;
    endcase
  end

  // data latches carry no reset: their power-up content is undefined
  always_ff @(posedge clk) begin
    if (commit_en) lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dir_q <= '1;
    else if (commit_en) dir_q <= dir_d;
  end

  assign lat_o = lat_q;
  assign dir_o = dir_q;

  AST_RESET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_o == '1)); // R1

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_i == PH_Q4) && (op_i == OP_WRITE)) |=> (lat_o == $past(wdata_i))); // R2

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_i == PH_Q4) && (op_i == OP_DIRW)) |=> (dir_o == $past(wdata_i))); // R3

  AST_BSET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_i == PH_Q4) && (op_i == OP_BSET)) |=> lat_o[$past(bit_i)]); // R5

  AST_BCLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_i == PH_Q4) && (op_i == OP_BCLR)) |=> !lat_o[$past(bit_i)]); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NONE) |=> ($stable(lat_o) && $stable(dir_o))); // R9

  AST_COMMIT_Q4_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i != PH_Q4) |=> ($stable(lat_o) && $stable(dir_o))); // R10

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] lat_i,
  input  logic [WIDTH-1:0] dir_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);

  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_pad
      assign pad_oe_o[g] = ~dir_i[g];
      assign pad_o[g]    = dir_i[g] ? 1'b0 : lat_i[g];
    end
  endgenerate

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       phase_i,
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] bit_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o
);

  logic             srst_n;
  phase_e           phase;
  op_e              op;
  logic [WIDTH-1:0] smp;
  logic [WIDTH-1:0] lat;
  logic [WIDTH-1:0] dir;

  assign phase = phase_e'(phase_i);
  assign op    = op_e'(op_i);

  gpio_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  gpio_sampler #(
    .WIDTH (WIDTH)
  ) i_sampler (
    .clk     (clk),
    .rst_n   (srst_n),
    .phase_i (phase),
    .op_i    (op),
    .pad_i   (pad_i),
    .smp_o   (smp)
  );

  gpio_latches #(
    .WIDTH (WIDTH),
    .IDX_W (IDX_W)
  ) i_latches (
    .clk     (clk),
    .rst_n   (srst_n),
    .phase_i (phase),
    .op_i    (op),
    .bit_i   (bit_i),
    .wdata_i (wdata_i),
    .smp_i   (smp),
    .lat_o   (lat),
    .dir_o   (dir)
  );

  gpio_pad_drive #(
    .WIDTH (WIDTH)
  ) i_pad_drive (
    .lat_i    (lat),
    .dir_i    (dir),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );

  assign rdata_o = smp;

  AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (pad_oe_o == '0)); // R1

endmodule

// File: tb/test_gpio_rmw_port.sv
module test_gpio_rmw_port;

  localparam int CLK_P    = 10;
  localparam int W        = 8;
  localparam int WD_LIMIT = 150000;

  localparam logic [2:0] C_NONE = 3'd0;
  localparam logic [2:0] C_WR   = 3'd1;
  localparam logic [2:0] C_RD   = 3'd2;
  localparam logic [2:0] C_BSET = 3'd3;
  localparam logic [2:0] C_BCLR = 3'd4;
  localparam logic [2:0] C_DIRW = 3'd5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   phase;
  logic [2:0]   op;
  logic [2:0]   bidx;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;
  logic [W-1:0] pad_i;
  logic [W-1:0] pad_o;
  logic [W-1:0] pad_oe;

  logic [W-1:0] ext_v;
  logic [W-1:0] pin;
  logic [W-1:0] hist [0:2];
  int           dly;
  int           nchk;
  int           nfail;
  logic         done;

  always #(CLK_P/2) clk = ~clk;

  // board: driven pins take the pad value, released pins the external pull level
  assign pin = (pad_oe & pad_o) | (~pad_oe & ext_v);

  always @(posedge clk) begin
    hist[0] <= pin;
    hist[1] <= hist[0];
    hist[2] <= hist[1];
  end

  assign pad_i = (dly == 0) ? pin : hist[dly-1];

  gpio_rmw_port i_gpio_rmw_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_i  (phase),
    .op_i     (op),
    .bit_i    (bidx),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .pad_i    (pad_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one instruction cycle, Q1..Q4; returns a quarter period after the Q4 edge
  task automatic cyc(input logic [2:0] o, input logic [2:0] b, input logic [W-1:0] d);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      phase = p[1:0];
      op    = o;
      bidx  = b;
      wdata = d;
    end
    @(posedge clk);
    #(CLK_P/4);
  endtask

  function automatic logic [W-1:0] pins_of(input logic [W-1:0] d, input logic [W-1:0] l,
                                           input logic [W-1:0] e);
    return (d & e) | (~d & l);
  endfunction

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d, w, e, l, exp_l, snap_o, snap_oe, snap_rd;
    nchk  = 0;
    nfail = 0;
    done  = 1'b0;
    dly   = 0;
    rst_n = 1'b0;
    phase = 2'd0;
    op    = C_NONE;
    bidx  = 3'd0;
    wdata = '0;
    ext_v = 8'h6C;

    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R1 oe in reset", pad_oe, 8'h00);
    chk("R1 drive in reset", pad_o, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #(CLK_P/4);
    chk("R1 oe after release", pad_oe, 8'h00);
    chk("R1 drive after release", pad_o, 8'h00);
    cyc(C_RD, 3'd0, 8'h00);
    chk("R1 all inputs read pull", rdata, 8'h6C);

    // R2 R3 R4: every direction pattern
    for (int i = 0; i < 256; i++) begin
      d = i[7:0];
      w = d * 8'd7 ^ 8'h96;
      e = ~d ^ 8'h33;
      ext_v = e;
      cyc(C_DIRW, 3'd0, d);
      chk("R3 enable", pad_oe, ~d);
      cyc(C_WR, 3'd0, w);
      chk("R2 drive", pad_o, w & ~d);
      cyc(C_RD, 3'd0, 8'h00);
      chk("R4 read", rdata, pins_of(d, w, e));
    end

    // R5 R6 R7: bit-set and bit-clear on a mixed port
    for (int b = 0; b < 8; b++) begin
      for (int s = 0; s < 2; s++) begin
        d = 8'h0F;
        l = (s == 0) ? 8'hC3 : 8'h3C;
        e = 8'h5A ^ b[7:0];
        ext_v = e;
        cyc(C_DIRW, 3'd0, d);
        cyc(C_WR, 3'd0, l);
        exp_l = pins_of(d, l, e);
        if (s == 0) begin
          exp_l[b] = 1'b1;
          cyc(C_BSET, b[2:0], 8'h00);
          chk("R5 bit-set outputs", pad_o, exp_l & ~d);
        end else begin
          exp_l[b] = 1'b0;
          cyc(C_BCLR, b[2:0], 8'h00);
          chk("R6 bit-clear outputs", pad_o, exp_l & ~d);
        end
        chk("R4 rmw sample", rdata, pins_of(d, l, e));
        cyc(C_DIRW, 3'd0, 8'h00);
        chk("R7 latch after rmw", pad_o, exp_l);
      end
    end

    // R7: input pin latch overwritten by its pin level
    ext_v = 8'hFF;
    cyc(C_DIRW, 3'd0, 8'h01);
    cyc(C_WR, 3'd0, 8'h00);
    cyc(C_BSET, 3'd5, 8'h00);
    cyc(C_DIRW, 3'd0, 8'h00);
    chk("R7 bit0 drives pin level", pad_o, 8'h21);

    // R9 and R10
    snap_o  = pad_o;
    snap_oe = pad_oe;
    snap_rd = rdata;
    cyc(C_NONE, 3'd2, 8'hFF);
    cyc(C_NONE, 3'd7, 8'h00);
    chk("R9 drive held", pad_o, snap_o);
    chk("R9 enable held", pad_oe, snap_oe);
    chk("R9 read data held", rdata, snap_rd);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk);
      phase = p[1:0];
      op    = C_WR;
      wdata = 8'hE7;
      @(posedge clk);
      #(CLK_P/4);
      chk("R10 no commit before Q4", pad_o, snap_o);
    end
    @(negedge clk);
    phase = 2'd3;
    @(posedge clk);
    #(CLK_P/4);
    chk("R10 commit at Q4", pad_o, 8'hE7);

    // R8: write followed directly by read, pin settling 0..3 phases
    for (int k = 0; k < 4; k++) begin
      dly = 0;
      cyc(C_WR, 3'd0, 8'hA5);
      cyc(C_NONE, 3'd0, 8'h00);
      dly = k;
      cyc(C_NONE, 3'd0, 8'h00);
      cyc(C_WR, 3'd0, 8'h5A);
      cyc(C_RD, 3'd0, 8'h00);
      chk("R8 back-to-back read", rdata, (k == 0) ? 8'h5A : 8'hA5);
      cyc(C_RD, 3'd0, 8'h00);
      chk("R8 later read settled", rdata, 8'h5A);
    end
    dly = 0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule